// File: doc/BRIEF.md
# Interrupt Request Flag Register

This block collects interrupt events from several sources into one 8-bit status register. An interrupt controller reads it. Four external request pins each pass through a synchronizer and an edge detector. Each pin has its own enable, which marks it as an interrupt input, and its own edge select. Two internal events also have flags: a counter overflow pulse from a timer, and a direct-transition event that the sleep logic raises when it carries out a direct transition. Each implemented flag drives a level request output. A combined request output is the OR of all of them.

Software reads the register at a single location with no wait states. A flag is acknowledged by writing 0 to its bit, and writing 1 leaves the bit as it was. Two reserved bits in the middle of the register always read as 1. The bit positions are fixed because the interrupt logic that follows decodes them:

| Bit | Content |
|-----|---------|
| 7 | direct-transition flag |
| 6 | timer overflow flag |
| 5:4 | reserved, read as 1 |
| 3:0 | flags for request pins 3 to 0 |

Top module: `irq_flag_reg`

## Requirements
- R1: After reset, every implemented flag is 0. A read returns 0x30, and all request outputs are low.
- R2: Bits 5 and 4 read as 1 whatever value has been written to them.
- R3: A write clears each implemented flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. The effect is visible from the cycle after the write.
- R4: Pin flag n (bit n, n = 0..3) sets when `pin_en[n]` is 1 and the selected edge is seen on `pin_in[n]`. With `pin_edge_sel[n]` = 1 the edge is rising, and with 0 it is falling. The opposite edge does not set the flag. The flag becomes visible 3 clock edges after the pin changes.
- R5: While `pin_en[n]` is 0, no edge sets pin flag n. An edge that occurred while the pin was disabled does not set the flag when the pin is enabled later.
- R6: A one-cycle pulse on `tmr_ovf_pulse` sets bit 6 at the next clock edge.
- R7: A one-cycle pulse on `dt_sleep_evt` sets bit 7 at the next clock edge only if `dt_enable` is 1 in the same cycle. With `dt_enable` at 0 the pulse is ignored.
- R8: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: `irq_pin`, `irq_tmr` and `irq_dt` follow their flags. `irq_any` is 1 exactly when at least one implemented flag is 1.
- R10: While `rd_en` is 1, `rd_data` shows the register contents in the same cycle. While `rd_en` is 0, `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 4 | Asynchronous external request pins |
| pin_en | input | 4 | Per pin: 1 marks the pin as an interrupt input |
| pin_edge_sel | input | 4 | Per pin: 1 selects the rising edge, 0 the falling edge |
| tmr_ovf_pulse | input | 1 | Timer counter overflow pulse |
| dt_sleep_evt | input | 1 | Pulse when a sleep request is carried out |
| dt_enable | input | 1 | Enables the direct-transition flag |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; a 0 clears the flag |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Read data, combinational |
| irq_pin | output | 4 | Level requests from the pin flags |
| irq_tmr | output | 1 | Level request from the timer flag |
| irq_dt | output | 1 | Level request from the direct-transition flag |
| irq_any | output | 1 | OR of all implemented flags |

## Verification
A stuck or wrongly cleared flag appears on its request line and on `irq_any` one cycle after the event or the write, and it appears on `rd_data` at the next read. Edge-detector history that drifts from the pin shows up three edges after the pin changes, as a flag raised on the wrong edge or a flag that never rises. Stale history after a pin was disabled shows up as a flag that rises with no new edge, and the sweep over pin, edge polarity and enable catches both cases.

// File: rtl/irqf_pkg.sv
`timescale 1ns/1ps
package irqf_pkg;
   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_kind_e;

   localparam int REG_W      = 8;
   localparam int PIN_CNT    = 4;
   localparam int FLAG_CNT   = PIN_CNT + 2;
   localparam int BIT_DT     = REG_W - 1;
   localparam int BIT_TMR    = REG_W - 2;

   function automatic logic edge_hit(input logic cur, input logic prv, input logic sel);
      return (sel == EDGE_RISE) ? (cur & ~prv) : (~cur & prv);
   endfunction
endpackage

// File: rtl/irqf_sync.sv
`timescale 1ns/1ps
module irqf_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irqf_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irqf_edge_det.sv
`timescale 1ns/1ps
module irqf_edge_det #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic sel_rise,
   input  logic arm,
   output logic hit
);
   import irqf_pkg::*;

   logic hist_q;

   // The history register follows the pin whether or not the pin is armed.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= RST_VAL;
      else        hist_q <= lvl;
   end

   assign hit = arm & edge_hit(lvl, hist_q, sel_rise);
endmodule

// File: rtl/irqf_flag_cell.sv
`timescale 1ns/1ps
module irqf_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_req,
   output logic flag_q
);
   // A set event takes priority over a clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (set_evt) flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
   end
endmodule

// File: rtl/irq_flag_reg.sv
`timescale 1ns/1ps
module irq_flag_reg #(
   parameter int   NUM_PINS    = 4,
   parameter int   DATA_W      = 8,
   parameter int   SYNC_STAGES = 2,
   parameter logic PIN_IDLE    = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [NUM_PINS-1:0] pin_en,
   input  logic [NUM_PINS-1:0] pin_edge_sel,
   input  logic                tmr_ovf_pulse,
   input  logic                dt_sleep_evt,
   input  logic                dt_enable,
   input  logic                wr_en,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                rd_en,
   output logic [DATA_W-1:0]   rd_data,
   output logic [NUM_PINS-1:0] irq_pin,
   output logic                irq_tmr,
   output logic                irq_dt,
   output logic                irq_any
);
   localparam int NUM_FLAGS = NUM_PINS + 2;
   localparam int RSV_W     = DATA_W - NUM_FLAGS;
   localparam int POS_DT    = DATA_W - 1;
   localparam int POS_TMR   = DATA_W - 2;
   localparam int IDX_TMR   = NUM_PINS;
   localparam int IDX_DT    = NUM_PINS + 1;

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("irq_flag_reg: NUM_PINS must be at least 1");
   end
   if (RSV_W < 1) begin : g_bad_width
      $error("irq_flag_reg: DATA_W leaves no reserved bits");
   end

   logic [NUM_PINS-1:0]  pin_sync;
   logic [NUM_PINS-1:0]  pin_hit;
   logic [NUM_FLAGS-1:0] set_vec;
   logic [NUM_FLAGS-1:0] clr_vec;
   logic [NUM_FLAGS-1:0] flag_vec;
   logic [NUM_FLAGS-1:0] wr_flag_bits;

   // Pin front end: synchronizer and edge detector per pin
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      irqf_sync #(
         .STAGES  (SYNC_STAGES),
         .RST_VAL (PIN_IDLE)
      ) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .d_async (pin_in[p]),
         .q_sync  (pin_sync[p])
      );

      irqf_edge_det #(
         .RST_VAL (PIN_IDLE)
      ) u_edge (
         .clk      (clk),
         .rst_n    (rst_n),
         .lvl      (pin_sync[p]),
         .sel_rise (pin_edge_sel[p]),
         .arm      (pin_en[p]),
         .hit      (pin_hit[p])
      );
   end

   // Set and clear vectors in flag order: pins, then timer, then direct transition
   assign set_vec = {dt_sleep_evt & dt_enable, tmr_ovf_pulse, pin_hit};
   assign wr_flag_bits = {wr_data[POS_DT], wr_data[POS_TMR], wr_data[NUM_PINS-1:0]};
   assign clr_vec = wr_en ? ~wr_flag_bits : '0;

   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      irqf_flag_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_evt (set_vec[f]),
         .clr_req (clr_vec[f]),
         .flag_q  (flag_vec[f])
      );
   end

   // Outputs
   assign irq_pin = flag_vec[NUM_PINS-1:0];
   assign irq_tmr = flag_vec[IDX_TMR];
   assign irq_dt  = flag_vec[IDX_DT];
   assign irq_any = |flag_vec;

   assign rd_data = rd_en ? {flag_vec[IDX_DT], flag_vec[IDX_TMR], {RSV_W{1'b1}},
                             flag_vec[NUM_PINS-1:0]}
                          : '0;
endmodule

// File: rtl/irqf_chk.sv
`timescale 1ns/1ps
module irqf_chk #(
   parameter int NUM_PINS = 4,
   parameter int DATA_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] pin_en,
   input logic                tmr_ovf_pulse,
   input logic                dt_sleep_evt,
   input logic                dt_enable,
   input logic                wr_en,
   input logic [DATA_W-1:0]   wr_data,
   input logic                rd_en,
   input logic [DATA_W-1:0]   rd_data,
   input logic [NUM_PINS-1:0] irq_pin,
   input logic                irq_tmr,
   input logic                irq_dt,
   input logic                irq_any
);
   localparam int RSV_W = DATA_W - NUM_PINS - 2;

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!irq_any); // R1
      end
   end

   AST_READ_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> rd_data == {irq_dt, irq_tmr, {RSV_W{1'b1}}, irq_pin}); // R10

   AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> rd_data == '0); // R10

   AST_TMR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf_pulse |=> irq_tmr); // R6

   AST_DT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (dt_sleep_evt && dt_enable) |=> irq_dt); // R7

   AST_DT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_dt && !(dt_sleep_evt && dt_enable)) |=> !irq_dt); // R7

   AST_TMR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[DATA_W-2] && !tmr_ovf_pulse) |=> !irq_tmr); // R3

   AST_TMR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_tmr && !(wr_en && !wr_data[DATA_W-2])) |=> irq_tmr); // R3

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_ovf_pulse && wr_en && !wr_data[DATA_W-2]) |=> irq_tmr); // R8

   AST_ANY_OR: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any == (irq_dt | irq_tmr | (|irq_pin))); // R9

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
      AST_PIN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
         (!pin_en[p] && !irq_pin[p]) |=> !irq_pin[p]); // R5
   end
endmodule

bind irq_flag_reg irqf_chk #(
   .NUM_PINS (NUM_PINS),
   .DATA_W   (DATA_W)
) u_irqf_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pin_en        (pin_en),
   .tmr_ovf_pulse (tmr_ovf_pulse),
   .dt_sleep_evt  (dt_sleep_evt),
   .dt_enable     (dt_enable),
   .wr_en         (wr_en),
   .wr_data       (wr_data),
   .rd_en         (rd_en),
   .rd_data       (rd_data),
   .irq_pin       (irq_pin),
   .irq_tmr       (irq_tmr),
   .irq_dt        (irq_dt),
   .irq_any       (irq_any)
);

// File: tb/irq_flag_reg_tb.sv
`timescale 1ns/1ps
module irq_flag_reg_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] pin_in = '0;
   logic [3:0] pin_en = '0;
   logic [3:0] pin_edge_sel = '0;
   logic       tmr_ovf_pulse = 1'b0;
   logic       dt_sleep_evt = 1'b0;
   logic       dt_enable = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic [3:0] irq_pin;
   logic       irq_tmr;
   logic       irq_dt;
   logic       irq_any;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   irq_flag_reg dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .pin_in        (pin_in),
      .pin_en        (pin_en),
      .pin_edge_sel  (pin_edge_sel),
      .tmr_ovf_pulse (tmr_ovf_pulse),
      .dt_sleep_evt  (dt_sleep_evt),
      .dt_enable     (dt_enable),
      .wr_en         (wr_en),
      .wr_data       (wr_data),
      .rd_en         (rd_en),
      .rd_data       (rd_data),
      .irq_pin       (irq_pin),
      .irq_tmr       (irq_tmr),
      .irq_dt        (irq_dt),
      .irq_any       (irq_any)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
      end
   endtask

   task automatic read_reg(output logic [7:0] v);
      @(negedge clk);
      rd_en = 1'b1;
      #1;
      v = rd_data;
      rd_en = 1'b0;
   endtask

   task automatic write_reg(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic drive_pin(input int p, input logic v);
      @(negedge clk);
      pin_in[p] = v;
      repeat (3) @(posedge clk);
   endtask

   initial begin : watchdog
      #(4 * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      logic [7:0] exp;
      idle(3);
      #1;
      // R1: values during reset, then after reset is released
      check("R1 irq_any in reset", {7'd0, irq_any}, 8'h00);
      rst_n = 1'b1;
      read_reg(v);
      check("R1 reset read", v, 8'h30);
      check("R1 outputs after reset", {irq_dt, irq_tmr, irq_any, 1'b0, irq_pin}, 8'h00);

      // R10: with rd_en low the data output is zero
      @(negedge clk);
      #1;
      check("R10 idle read data", rd_data, 8'h00);

      // R4 R5 R9: sweep over pin, edge polarity and enable
      for (int p = 0; p < 4; p++) begin
         for (int s = 0; s < 2; s++) begin
            for (int e = 0; e < 2; e++) begin
               @(negedge clk);
               pin_en = '0;
               pin_edge_sel[p] = s[0];
               pin_in[p] = ~s[0];
               idle(5);
               write_reg(8'h00);
               @(negedge clk);
               pin_en[p] = e[0];
               drive_pin(p, s[0]);
               read_reg(v);
               exp = 8'h30 | (e[0] ? 8'(1 << p) : 8'h00);
               check(e[0] ? "R4 selected edge sets" : "R5 disabled pin ignored", v, exp);
               check("R9 irq_pin", {4'd0, irq_pin}, {4'd0, exp[3:0]});
               check("R9 irq_any", {7'd0, irq_any}, {7'd0, e[0]});
               write_reg(8'h00);
               drive_pin(p, ~s[0]);
               read_reg(v);
               check("R4 opposite edge ignored", v, 8'h30);
            end
         end
      end

      // R5: an edge while disabled does not fire when the pin is enabled later
      @(negedge clk);
      pin_en = '0;
      pin_in = '0;
      pin_edge_sel = 4'hF;
      idle(5);
      write_reg(8'h00);
      drive_pin(2, 1'b1);
      idle(2);
      @(negedge clk);
      pin_en = 4'hF;
      idle(5);
      read_reg(v);
      check("R5 no stale edge", v, 8'h30);
      drive_pin(2, 1'b0);
      read_reg(v);
      check("R5 falling ignored with rising select", v, 8'h30);

      // R6: timer pulse
      @(negedge clk);
      tmr_ovf_pulse = 1'b1;
      @(posedge clk);
      #1;
      tmr_ovf_pulse = 1'b0;
      read_reg(v);
      check("R6 timer flag", v, 8'h70);
      check("R9 irq_tmr", {7'd0, irq_tmr}, 8'h01);

      // R7: direct-transition event is ignored while dt_enable is low
      @(negedge clk);
      dt_sleep_evt = 1'b1;
      dt_enable = 1'b0;
      @(posedge clk);
      #1;
      dt_sleep_evt = 1'b0;
      read_reg(v);
      check("R7 gated off", v, 8'h70);
      @(negedge clk);
      dt_sleep_evt = 1'b1;
      dt_enable = 1'b1;
      @(posedge clk);
      #1;
      dt_sleep_evt = 1'b0;
      read_reg(v);
      check("R7 direct transition flag", v, 8'hF0);

      // Set all four pin flags with rising edges
      for (int p = 0; p < 4; p++) drive_pin(p, 1'b1);
      read_reg(v);
      check("R4 all pins set", v, 8'hFF);

      // R3: writing ones leaves every flag set
      write_reg(8'hFF);
      read_reg(v);
      check("R3 write ones keeps", v, 8'hFF);
      // R3: clear one implemented bit at a time; R2: reserved bits stay 1
      exp = 8'hFF;
      for (int b = 0; b < 8; b++) begin
         if (b == 4 || b == 5) continue;
         write_reg(~8'(1 << b));
         exp = exp & ~8'(1 << b);
         read_reg(v);
         check("R3 clear single bit", v, exp);
      end
      write_reg(8'hCF);
      read_reg(v);
      check("R2 reserved bits hold ones", v, 8'h30);

      // R8: set and clear in the same cycle
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = 8'h00;
      tmr_ovf_pulse = 1'b1;
      dt_sleep_evt = 1'b1;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      tmr_ovf_pulse = 1'b0;
      dt_sleep_evt = 1'b0;
      read_reg(v);
      check("R8 set wins", v, 8'hF0);
      check("R9 irq_dt", {7'd0, irq_dt}, 8'h01);
      write_reg(8'h00);
      read_reg(v);
      check("R3 final clear", v, 8'h30);
      check("R9 irq_any low", {7'd0, irq_any}, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule